// File: doc/BRIEF.md
# Message-Signalled Interrupt Table Dispatcher

This block turns interrupt notifications from a host device into either a wired interrupt pulse or a memory-write message. Software programs a small table of five message entries through a 32-bit little-endian register bus. Each entry is 16 bytes long and holds four words, in this order: target address bits 31:0, target address bits 63:32, the message data word, and a vector-control word. The control word is only stored. An eight-byte pending-bit window sits 256 bytes above the start of the table. It always reads as zero, and writes to it have no effect.

A notification carries a vector number. The `wire_mode` control input decides how each notification is delivered. When `wire_mode` is high, the notification becomes a one-cycle pulse on one of four wired interrupt lines. When `wire_mode` is low, the block issues one 32-bit write of the entry's data word to the entry's 64-bit address. That write goes out on a valid/ready request port. A write that has not yet been accepted is held stable. One further message notification can wait in a holding slot. Any notification that arrives while the slot is full is dropped, and a sticky overflow flag is set.

On the register bus, a request is accepted when `req_valid` and `req_ready` are both high. One response follows in the next cycle. `req_ready` stays low while a response waits for `rsp_ready`, and the response holds its data stable until `rsp_ready` accepts it. On the message port, the consumer applies back-pressure by holding `mw_ready` low. While it does, `mw_addr` and `mw_data` do not change.

Top module: `msi_dispatch`

## Requirements
- R1: Reset, and the cycles while reset is asserted, leave all wired lines low, `mw_valid` and `msg_overflow` low, the holding slot empty and every table word zero.
- R2: A 4-byte access to table byte offset 16·v + 4·k (counted from `CFG_BASE`) reaches word k of entry v. Word 0 is address bits 31:0, word 1 is address bits 63:32, word 2 is data and word 3 is vector control. A read returns the word in `rsp_rdata[31:0]`, with the upper half zero.
- R3: An 8-byte access at any 4-byte-aligned table offset acts as two word accesses, the lower address first. `req_wdata[31:0]` goes to the word at the given offset and `req_wdata[63:32]` to the next word. A read returns {next word, word}.
- R4: An access is rejected with `rsp_err`=1 and `rsp_rdata`=0, and leaves the table unchanged, if any of these holds:
  - its address is not a multiple of 4;
  - it does not lie wholly inside the 80-byte table or the 8-byte pending window;
  - its offset plus its size runs past the end of the region it starts in.
- R5: An access that lies wholly inside the pending window, at table offset 256 to 263, gets `rsp_err`=0 and always reads 0. A write there changes nothing.
- R6: While a response waits for `rsp_ready`, `req_ready` is low and `rsp_valid`, `rsp_rdata` and `rsp_err` stay stable.
- R7: With `wire_mode`=1, a notification for vector v<4 drives `irq_o[v]` high for exactly the next cycle, and no message is issued.
- R8: With `wire_mode`=0, a notification for vector v<5 arriving while the message port is idle raises `mw_valid` in the next cycle. It presents `mw_addr` = {word 1, word 0} and `mw_data` = word 2 of entry v.
- R9: While `mw_valid`=1 and `mw_ready`=0, `mw_valid`, `mw_addr` and `mw_data` stay unchanged.
- R10: A message notification arriving while a write waits for its handshake is kept in a one-deep slot. It is issued in the cycle after that handshake completes.
- R11: A message notification arriving while the slot is full is dropped and sets `msg_overflow`. The flag stays set until reset.
- R12: A notification for a vector of 5 or more does nothing in either mode. A notification for vector 4 does nothing in wired mode.
- R13: A message takes its address and data from the table as it stands before any bus write accepted in the same cycle as the message's launch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register request valid |
| req_ready | output | 1 | Register request ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 8-byte access, 0 = 4-byte access |
| req_addr | input | REG_AW | Byte address in device register space |
| req_wdata | input | 64 | Write data, little-endian |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response ready |
| rsp_rdata | output | 64 | Read data |
| rsp_err | output | 1 | Access rejected |
| wire_mode | input | 1 | 1 = wired pulse delivery, 0 = message delivery |
| ntf_valid | input | 1 | Notification strobe |
| ntf_vec | input | VEC_W | Notified vector number |
| irq_o | output | NUM_WIRED | Wired interrupt pulses |
| mw_valid | output | 1 | Message write valid |
| mw_ready | input | 1 | Message write ready |
| mw_addr | output | 64 | Message target address |
| mw_data | output | 32 | Message data word |
| msg_overflow | output | 1 | Sticky dropped-notification flag |

## Verification
A message launch reads an entry of the table. A bus write to the same entry can be accepted on the very same clock edge. The bench provokes this by driving a notification for vector 1 and a write to entry 1's data word in one cycle. It then expects the message to carry the old data word, and a later notification to carry the new one. The bench also lands a message handshake and a queued notification on the same edge. It expects the queued vector to come out in the next cycle, and the vector dropped while the slot was full never to appear.

// File: rtl/msi_dispatch_pkg.sv
package msi_dispatch_pkg;

  typedef struct packed {
    logic [63:0] addr;
    logic [31:0] data;
  } msi_msg_t;

  function automatic int unsigned pending_bytes(input int unsigned nvec);
    return ((nvec + 63) / 64) * 8;
  endfunction

endpackage

// File: rtl/msi_reg_decode.sv
module msi_reg_decode #(
  parameter int unsigned AW        = 12,
  parameter int unsigned BASE      = 768,
  parameter int unsigned TBL_BYTES = 80,
  parameter int unsigned PND_GAP   = 256,
  parameter int unsigned PND_BYTES = 8,
  parameter int unsigned IDX_W     = 5
) (
  input  logic [AW-1:0]    addr,
  input  logic             wide,
  output logic             hit_tbl,
  output logic             bad,
  output logic [IDX_W-1:0] widx
);

  localparam int unsigned TBL_LO = BASE;
  localparam int unsigned TBL_HI = BASE + TBL_BYTES;
  localparam int unsigned PND_LO = BASE + PND_GAP;
  localparam int unsigned PND_HI = PND_LO + PND_BYTES;

  int unsigned a_lo;
  int unsigned a_end;
  logic        aligned;
  logic        hit_pnd;

  always_comb begin
    a_lo    = 32'(addr);
    a_end   = a_lo + (wide ? 32'd8 : 32'd4);
    aligned = (addr[1:0] == 2'b00);
    hit_tbl = aligned && (a_lo >= TBL_LO) && (a_end <= TBL_HI);
    hit_pnd = aligned && (a_lo >= PND_LO) && (a_end <= PND_HI);
    bad     = !(hit_tbl || hit_pnd);
    widx    = IDX_W'((a_lo - TBL_LO) >> 2);
  end

endmodule

// File: rtl/msi_vec_table.sv
module msi_vec_table
  import msi_dispatch_pkg::*;
#(
  parameter int unsigned TBL_WORDS = 20,
  parameter int unsigned IDX_W     = 5,
  parameter int unsigned VEC_W     = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc,
  input  logic             wr,
  input  logic             wide,
  input  logic             hit_tbl,
  input  logic             bad,
  input  logic [IDX_W-1:0] widx,
  input  logic [63:0]      wdata,
  input  logic             rsp_ready,
  output logic             rsp_valid,
  output logic [63:0]      rsp_rdata,
  output logic             rsp_err,
  input  logic [VEC_W-1:0] rd_vec,
  output msi_msg_t         msg
);

  logic [TBL_WORDS-1:0][31:0] tbl;
  logic [IDX_W-1:0]           widx_nx;
  logic [IDX_W-1:0]           ent_base;
  logic [63:0]                rd_word;

  assign widx_nx  = widx + IDX_W'(1);
  assign ent_base = {rd_vec, 2'b00};

  // launch read port: sees the table before this cycle's bus write
  always_comb begin
    msg.addr = {tbl[ent_base + IDX_W'(1)], tbl[ent_base]};
    msg.data = tbl[ent_base + IDX_W'(2)];
  end

  always_comb begin
    rd_word = '0;
    if (!wr && hit_tbl) begin
      rd_word[31:0] = tbl[widx];
      if (wide) rd_word[63:32] = tbl[widx_nx];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tbl <= '0;
    end else if (acc && wr && hit_tbl) begin
      tbl[widx] <= wdata[31:0];
      if (wide) tbl[widx_nx] <= wdata[63:32];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else if (acc) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= rd_word;
      rsp_err   <= bad;
    end else if (rsp_valid && rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  p_bad_keeps_table_r4: assert property (@(posedge clk) disable iff (!rst_n)
    acc && bad |=> $stable(tbl));

  p_rsp_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata) && $stable(rsp_err));

endmodule

// File: rtl/msi_msg_issue.sv
module msi_msg_issue
  import msi_dispatch_pkg::*;
#(
  parameter int unsigned VEC_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ntf_hit,
  input  logic [VEC_W-1:0] ntf_vec,
  input  msi_msg_t         msg,
  output logic [VEC_W-1:0] rd_vec,
  output logic             mw_valid,
  input  logic             mw_ready,
  output logic [63:0]      mw_addr,
  output logic [31:0]      mw_data,
  output logic             overflow
);

  logic             hold_v;
  logic [VEC_W-1:0] hold_vec;
  logic             fire;
  logic             from_hold;
  logic             from_ntf;
  logic             launch;

  always_comb begin
    fire      = mw_valid && mw_ready;
    from_hold = hold_v && fire;
    from_ntf  = ntf_hit && (!mw_valid || (fire && !hold_v));
    launch    = from_hold || from_ntf;
    rd_vec    = from_hold ? hold_vec : ntf_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mw_valid <= 1'b0;
      mw_addr  <= '0;
      mw_data  <= '0;
    end else if (launch) begin
      mw_valid <= 1'b1;
      mw_addr  <= msg.addr;
      mw_data  <= msg.data;
    end else if (fire) begin
      mw_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_v   <= 1'b0;
      hold_vec <= '0;
      overflow <= 1'b0;
    end else if (from_hold) begin
      hold_v   <= ntf_hit;
      hold_vec <= ntf_vec;
    end else if (ntf_hit && mw_valid && !fire) begin
      if (!hold_v) begin
        hold_v   <= 1'b1;
        hold_vec <= ntf_vec;
      end else begin
        overflow <= 1'b1;
      end
    end
  end

  p_mw_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mw_valid && !mw_ready |=> mw_valid && $stable(mw_addr) && $stable(mw_data));

  p_hold_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    hold_v |-> mw_valid);

  p_hold_drain_r10: assert property (@(posedge clk) disable iff (!rst_n)
    hold_v && mw_ready |=> mw_valid);

  p_ovf_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  p_ovf_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow) |-> $past(hold_v && ntf_hit && !mw_ready));

endmodule

// File: rtl/msi_wired_pulse.sv
module msi_wired_pulse #(
  parameter int unsigned NUM_WIRED = 4,
  parameter int unsigned VEC_W     = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 hit,
  input  logic [VEC_W-1:0]     ntf_vec,
  output logic [NUM_WIRED-1:0] irq
);

  for (genvar i = 0; i < NUM_WIRED; i++) begin : g_line
    logic q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= 1'b0;
      else        q <= hit && (ntf_vec == VEC_W'(i));
    end
    assign irq[i] = q;

    p_irq_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
      q |-> $past(hit && (ntf_vec == VEC_W'(i))));
  end

  p_irq_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq));

endmodule

// File: rtl/msi_dispatch.sv
module msi_dispatch
  import msi_dispatch_pkg::*;
#(
  parameter int unsigned NUM_VEC   = 5,
  parameter int unsigned NUM_WIRED = 4,
  parameter int unsigned REG_AW    = 12,
  parameter int unsigned CFG_BASE  = 768,
  localparam int unsigned VEC_W    = $clog2(NUM_VEC)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_write,
  input  logic                 req_wide,
  input  logic [REG_AW-1:0]    req_addr,
  input  logic [63:0]          req_wdata,
  output logic                 rsp_valid,
  input  logic                 rsp_ready,
  output logic [63:0]          rsp_rdata,
  output logic                 rsp_err,
  input  logic                 wire_mode,
  input  logic                 ntf_valid,
  input  logic [VEC_W-1:0]     ntf_vec,
  output logic [NUM_WIRED-1:0] irq_o,
  output logic                 mw_valid,
  input  logic                 mw_ready,
  output logic [63:0]          mw_addr,
  output logic [31:0]          mw_data,
  output logic                 msg_overflow
);

  localparam int unsigned IDX_W     = VEC_W + 2;
  localparam int unsigned TBL_WORDS = NUM_VEC * 4;
  localparam int unsigned TBL_BYTES = NUM_VEC * 16;
  localparam int unsigned PND_BYTES = pending_bytes(NUM_VEC);
  localparam int unsigned PND_GAP   = 256;

  logic             acc;
  logic             hit_tbl;
  logic             bad;
  logic [IDX_W-1:0] widx;
  logic             ntf_msg;
  logic             ntf_wire;
  logic [VEC_W-1:0] rd_vec;
  msi_msg_t         msg;

  assign req_ready = !rsp_valid;
  assign acc       = req_valid && req_ready;
  assign ntf_msg   = ntf_valid && !wire_mode && (32'(ntf_vec) < NUM_VEC);
  assign ntf_wire  = ntf_valid && wire_mode;

  msi_reg_decode #(
    .AW(REG_AW), .BASE(CFG_BASE), .TBL_BYTES(TBL_BYTES),
    .PND_GAP(PND_GAP), .PND_BYTES(PND_BYTES), .IDX_W(IDX_W)
  ) u_decode (
    .addr(req_addr), .wide(req_wide),
    .hit_tbl(hit_tbl), .bad(bad), .widx(widx)
  );

  msi_vec_table #(
    .TBL_WORDS(TBL_WORDS), .IDX_W(IDX_W), .VEC_W(VEC_W)
  ) u_table (
    .clk(clk), .rst_n(rst_n), .acc(acc), .wr(req_write), .wide(req_wide),
    .hit_tbl(hit_tbl), .bad(bad), .widx(widx), .wdata(req_wdata),
    .rsp_ready(rsp_ready), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .rsp_err(rsp_err), .rd_vec(rd_vec), .msg(msg)
  );

  msi_msg_issue #(.VEC_W(VEC_W)) u_issue (
    .clk(clk), .rst_n(rst_n), .ntf_hit(ntf_msg), .ntf_vec(ntf_vec),
    .msg(msg), .rd_vec(rd_vec), .mw_valid(mw_valid), .mw_ready(mw_ready),
    .mw_addr(mw_addr), .mw_data(mw_data), .overflow(msg_overflow)
  );

  msi_wired_pulse #(.NUM_WIRED(NUM_WIRED), .VEC_W(VEC_W)) u_wired (
    .clk(clk), .rst_n(rst_n), .hit(ntf_wire), .ntf_vec(ntf_vec), .irq(irq_o)
  );

  p_wire_no_launch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ntf_valid && wire_mode && !mw_valid |=> !mw_valid);

endmodule

// File: tb/msi_dispatch_tb_top.sv
module msi_dispatch_tb_top;

  localparam int CFG = 768;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_wide = 1'b0;
  logic [11:0] req_addr = '0;
  logic [63:0] req_wdata = '0;
  logic        req_ready, rsp_valid, rsp_err;
  logic        rsp_ready = 1'b1;
  logic [63:0] rsp_rdata;
  logic        wire_mode = 1'b0, ntf_valid = 1'b0;
  logic [2:0]  ntf_vec = '0;
  logic [3:0]  irq_o;
  logic        mw_valid, msg_overflow;
  logic        mw_ready = 1'b1;
  logic [63:0] mw_addr;
  logic [31:0] mw_data;

  int total = 0;
  int bad = 0;
  logic [31:0] mdl [20];

  always #2 clk = ~clk;

  msi_dispatch dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_wide(req_wide), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .wire_mode(wire_mode),
    .ntf_valid(ntf_valid), .ntf_vec(ntf_vec), .irq_o(irq_o),
    .mw_valid(mw_valid), .mw_ready(mw_ready), .mw_addr(mw_addr),
    .mw_data(mw_data), .msg_overflow(msg_overflow)
  );

  task automatic chk(input string tag, input logic [95:0] act, input logic [95:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic bus(input logic w, input logic wide, input int off,
                     input logic [63:0] wd, output logic [63:0] rd, output logic er);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_wide = wide;
    req_addr = 12'(CFG + off); req_wdata = wd;
    @(posedge clk); #1;
    rd = rsp_rdata; er = rsp_err;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  function automatic logic exp_err(input int off, input bit wide);
    int e = off + (wide ? 8 : 4);
    if ((off & 3) != 0) return 1'b1;
    return !((off >= 0 && e <= 80) || (off >= 256 && e <= 264));
  endfunction

  function automatic logic [63:0] exp_rd(input int off, input bit wide);
    if (exp_err(off, wide) || off >= 80) return 64'd0;
    return {wide ? mdl[off/4 + 1] : 32'd0, mdl[off/4]};
  endfunction

  function automatic logic [31:0] pat(input int i);
    return 32'((i + 1) * 32'h01030507) ^ 32'h5A5A_0000;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 irq in reset", 96'(irq_o), 96'd0);
    chk("R1 mw_valid in reset", 96'(mw_valid), 96'd0);
    chk("R1 overflow in reset", 96'(msg_overflow), 96'd0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 20; i++) mdl[i] = 32'd0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [63:0] rd, rd0;
    logic er;
    logic [31:0] old;

    do_reset();
    for (int i = 0; i < 20; i++) begin
      bus(1'b0, 1'b0, 4 * i, 64'd0, rd, er);
      chk("R1 table zero after reset", 96'(rd), 96'd0);
    end

    // R2: word writes and reads
    for (int i = 0; i < 20; i++) begin
      bus(1'b1, 1'b0, 4 * i, {32'hFFFF_FFFF, pat(i)}, rd, er);
      mdl[i] = pat(i);
      chk("R2 write ok", 96'(er), 96'd0);
    end
    for (int i = 0; i < 20; i++) begin
      bus(1'b0, 1'b0, 4 * i, 64'd0, rd, er);
      chk("R2 word readback", 96'(rd), 96'(exp_rd(4 * i, 1'b0)));
    end

    // R3: 8-byte writes split lower first, wide reads everywhere
    bus(1'b1, 1'b1, 16, 64'h1111_2222_3333_4444, rd, er);
    mdl[4] = 32'h3333_4444; mdl[5] = 32'h1111_2222;
    bus(1'b1, 1'b1, 52, 64'h9999_AAAA_BBBB_CCCC, rd, er);
    mdl[13] = 32'hBBBB_CCCC; mdl[14] = 32'h9999_AAAA;
    for (int off = 0; off <= 72; off += 4) begin
      bus(1'b0, 1'b1, off, 64'd0, rd, er);
      chk("R3 wide read", 96'({er, rd}), 96'({1'b0, exp_rd(off, 1'b1)}));
    end

    // R4 / R5: address sweep of both sizes
    for (int off = -16; off <= 276; off += 4) begin
      for (int w = 0; w < 2; w++) begin
        bus(1'b0, w[0], off, 64'd0, rd, er);
        chk((off >= 256 && off < 264) ? "R5 pending read" : "R4 range err",
            96'(er), 96'(exp_err(off, w[0])));
        chk("R4 sweep data", 96'(rd), 96'(exp_rd(off, w[0])));
      end
    end
    foreach (mdl[k]) if (k < 0) $display("unused");
    bus(1'b0, 1'b0, 2, 64'd0, rd, er);
    chk("R4 misaligned", 96'({er, rd}), 96'({1'b1, 64'd0}));
    bus(1'b1, 1'b0, 6, 64'hFFFF_FFFF, rd, er);
    chk("R4 misaligned write err", 96'(er), 96'd1);
    bus(1'b1, 1'b1, 76, 64'hDEAD_DEAD_DEAD_DEAD, rd, er);
    chk("R4 crossing write err", 96'(er), 96'd1);
    bus(1'b0, 1'b0, 76, 64'd0, rd, er);
    chk("R4 table unchanged", 96'(rd), 96'(mdl[19]));
    bus(1'b0, 1'b0, 4, 64'd0, rd, er);
    chk("R4 misaligned write no effect", 96'(rd), 96'(mdl[1]));
    bus(1'b1, 1'b1, 256, 64'hFFFF_FFFF_FFFF_FFFF, rd, er);
    chk("R5 pending write ok", 96'(er), 96'd0);
    bus(1'b0, 1'b1, 256, 64'd0, rd, er);
    chk("R5 pending still zero", 96'({er, rd}), 96'd0);

    // R6: response back-pressure
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_wide = 1'b0; req_addr = 12'(CFG + 8);
    @(posedge clk); #1;
    rd0 = rsp_rdata;
    @(negedge clk);
    req_valid = 1'b0; rsp_ready = 1'b0;
    for (int c = 0; c < 3; c++) begin
      @(posedge clk); #1;
      chk("R6 rsp held", 96'({rsp_valid, req_ready, rsp_rdata}), 96'({2'b10, rd0}));
    end
    @(negedge clk);
    rsp_ready = 1'b1;
    @(posedge clk); #1;
    chk("R6 rsp released", 96'({rsp_valid, req_ready}), 96'({2'b01}));
    chk("R6 rsp data", 96'(rd0), 96'(mdl[2]));

    // R7 / R12: wired pulses
    wire_mode = 1'b1;
    for (int v = 0; v < 8; v++) begin
      @(negedge clk);
      ntf_valid = 1'b1; ntf_vec = 3'(v);
      @(posedge clk); #1;
      chk((v < 4) ? "R7 wired pulse" : "R12 wired ignored",
          96'(irq_o), 96'((v < 4) ? (4'b1 << v) : 4'b0));
      chk("R7 no message in wired mode", 96'(mw_valid), 96'd0);
      @(negedge clk);
      ntf_valid = 1'b0;
      @(posedge clk); #1;
      chk("R7 single cycle", 96'(irq_o), 96'd0);
    end

    // R8 / R12: message path
    wire_mode = 1'b0;
    for (int v = 0; v < 8; v++) begin
      @(negedge clk);
      ntf_valid = 1'b1; ntf_vec = 3'(v);
      @(posedge clk); #1;
      if (v < 5)
        chk("R8 message", 96'({mw_valid, mw_addr, mw_data}),
            96'({1'b1, mdl[4*v+1], mdl[4*v], mdl[4*v+2]}));
      else
        chk("R12 bad vector ignored", 96'(mw_valid), 96'd0);
      chk("R8 no wired pulse", 96'(irq_o), 96'd0);
      @(negedge clk);
      ntf_valid = 1'b0;
      @(posedge clk); #1;
      chk("R8 handshake done", 96'(mw_valid), 96'd0);
    end

    // R9 / R10 / R11: back-pressure, holding slot, overflow
    @(negedge clk);
    mw_ready = 1'b0; ntf_valid = 1'b1; ntf_vec = 3'd0;
    @(posedge clk); #1;
    chk("R9 first launch", 96'({mw_valid, mw_addr, mw_data}),
        96'({1'b1, mdl[1], mdl[0], mdl[2]}));
    @(negedge clk);
    ntf_vec = 3'd2;
    @(posedge clk); #1;
    chk("R10 queued no overflow", 96'(msg_overflow), 96'd0);
    @(negedge clk);
    ntf_vec = 3'd3;
    @(posedge clk); #1;
    chk("R11 overflow set", 96'(msg_overflow), 96'd1);
    @(negedge clk);
    ntf_valid = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    chk("R9 held stable", 96'({mw_valid, mw_addr, mw_data}),
        96'({1'b1, mdl[1], mdl[0], mdl[2]}));
    @(negedge clk);
    mw_ready = 1'b1;
    @(posedge clk); #1;
    chk("R10 queued issued", 96'({mw_valid, mw_addr, mw_data}),
        96'({1'b1, mdl[9], mdl[8], mdl[10]}));
    @(posedge clk); #1;
    chk("R10 dropped vector absent", 96'(mw_valid), 96'd0);
    chk("R11 overflow sticky", 96'(msg_overflow), 96'd1);

    // R13: launch and bus write on the same edge
    old = mdl[6];
    @(negedge clk);
    ntf_valid = 1'b1; ntf_vec = 3'd1;
    req_valid = 1'b1; req_write = 1'b1; req_wide = 1'b0;
    req_addr = 12'(CFG + 24); req_wdata = 64'h0000_0000_C0DE_F00D;
    @(posedge clk); #1;
    chk("R13 pre-write data", 96'({mw_valid, mw_data}), 96'({1'b1, old}));
    @(negedge clk);
    ntf_valid = 1'b0; req_valid = 1'b0;
    mdl[6] = 32'hC0DE_F00D;
    @(posedge clk);
    @(negedge clk);
    ntf_valid = 1'b1;
    @(posedge clk); #1;
    chk("R13 post-write data", 96'({mw_valid, mw_data}), 96'({1'b1, mdl[6]}));
    @(negedge clk);
    ntf_valid = 1'b0;
    @(posedge clk);

    // R1: reset clears overflow and table
    do_reset();
    @(posedge clk); #1;
    chk("R1 overflow cleared", 96'(msg_overflow), 96'd0);
    bus(1'b0, 1'b1, 24, 64'd0, rd, er);
    chk("R1 table cleared", 96'(rd), 96'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule